// File: doc/BRIEF.md
# Floating-point single load decoder and address generator

This block sits in the issue stage of an integer/floating-point core. It receives a 32-bit instruction word, the current program counter, and the values already read for the two integer source registers named by that word. It recognises the four single-precision floating-point loads: displacement and indexed addressing, each with or without base update. It reports whether the word is a legal load, whether it is an illegal update encoding, the destination floating-point register, the 32-bit effective address, a base-register writeback request, and the next program counter.

Register file access, the memory read and the single-to-double conversion happen outside the block. The computation is combinational. A parameter selects whether all results pass through one output register stage, which is the default, or leave the block directly.

The field positions use big-endian bit numbering, so bit 0 is the word's most significant bit. The primary opcode is instr[31:26], the destination FPR is instr[25:21], RA is instr[20:16], RB is instr[15:11], the extended opcode is instr[10:1], and the displacement is instr[15:0]. instr[0] is ignored.

Top module: `fsl_agen`

## Requirements
- R1: Primary opcode 48 is a legal displacement load: o_valid=1, o_fd=instr[25:21], o_ea = low 32 bits of (base + sign-extended instr[15:0]), and no writeback.
- R2: Primary opcode 49 is a displacement load with update: o_ea = low 32 bits of (i_gpr_a + sign-extended displacement), o_wb_en=1, o_wb_idx=RA, and o_wb_val = o_ea zero-extended to 64 bits.
- R3: Primary opcode 31 with extended opcode 535 is a legal indexed load: o_ea = low 32 bits of (base + i_gpr_b), with no writeback.
- R4: Primary opcode 31 with extended opcode 567 is an indexed load with update: o_ea = low 32 bits of (i_gpr_a + i_gpr_b), and the writeback carries RA and the zero-extended o_ea.
- R5: In the two non-update forms, an RA field of 0 makes the base a literal zero, whatever the value on i_gpr_a.
- R6: An update form with RA=0 gives o_illegal=1, o_valid=0 and o_wb_en=0.
- R7: Any other word, including opcode 31 with another extended opcode, gives o_valid=0, o_illegal=0 and o_wb_en=0.
- R8: Address arithmetic wraps modulo 2^64 and is then truncated to 32 bits, with no overflow indication.
- R9: o_next_pc equals i_pc + 4 modulo 2^32.
- R10: With the output stage enabled, every output reflects the inputs sampled at the previous rising clock edge, and reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_instr | input | 32 | Instruction word |
| i_pc | input | 32 | Program counter of the instruction |
| i_gpr_a | input | 64 | Value of the register named by RA |
| i_gpr_b | input | 64 | Value of the register named by RB |
| o_valid | output | 1 | Legal single-precision FP load recognised |
| o_illegal | output | 1 | Update form encoded with RA=0 |
| o_fd | output | 5 | Destination floating-point register |
| o_ea | output | 32 | Effective address |
| o_wb_en | output | 1 | Base-register writeback request |
| o_wb_idx | output | 5 | Register to write back |
| o_wb_val | output | 64 | Value to write back |
| o_next_pc | output | 32 | Next program counter |

## Verification
With the default output stage, every result is due exactly one rising edge after the inputs are applied. The bench drives inputs on a falling edge, checks them on the next falling edge after one rising edge has passed, and never samples at an edge. One scenario samples just before the capturing edge to confirm that the outputs still show the previous word, and one confirms that all outputs are zero while reset is held. The checker compares registered outputs against inputs delayed by one cycle, and it only starts once a full cycle has passed since reset.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

   localparam int INSTR_W   = 32;
   localparam int RIDX_W    = 5;
   localparam int DISP_W    = 16;
   localparam int XO_W      = 10;
   localparam int OPCD_W    = 6;

   localparam logic [OPCD_W-1:0] OP_LD_DISP   = 6'd48;
   localparam logic [OPCD_W-1:0] OP_LD_DISP_U = 6'd49;
   localparam logic [OPCD_W-1:0] OP_EXT       = 6'd31;
   localparam logic [XO_W-1:0]   XO_LD_IDX    = 10'd535;
   localparam logic [XO_W-1:0]   XO_LD_IDX_U  = 10'd567;

   typedef enum logic [2:0] {
      LDF_NONE   = 3'd0,
      LDF_DISP   = 3'd1,
      LDF_DISP_U = 3'd2,
      LDF_IDX    = 3'd3,
      LDF_IDX_U  = 3'd4
   } ld_form_e;

   typedef struct packed {
      ld_form_e            form;
      logic [RIDX_W-1:0]   fd;
      logic [RIDX_W-1:0]   ra;
      logic [RIDX_W-1:0]   rb;
      logic [DISP_W-1:0]   disp;
   } ld_dec_t;

endpackage

// File: rtl/fsl_dec.sv
module fsl_dec
   import fsl_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output ld_dec_t            dec
);

   logic [OPCD_W-1:0] opcd;
   logic [XO_W-1:0]   xo;
   ld_form_e          form;

   // big-endian bit k maps to vector index INSTR_W-1-k
   assign opcd = instr[INSTR_W-1 -: OPCD_W];
   assign xo   = instr[XO_W:1];

   always_comb begin
      form = LDF_NONE;
      unique case (opcd)
         OP_LD_DISP:   form = LDF_DISP;
         OP_LD_DISP_U: form = LDF_DISP_U;
         OP_EXT: begin
            if (xo == XO_LD_IDX)
               form = LDF_IDX;
            else if (xo == XO_LD_IDX_U)
               form = LDF_IDX_U;
            else
               form = LDF_NONE;
         end
         default:      form = LDF_NONE;
      endcase
   end

   assign dec.form = form;
   assign dec.fd   = instr[25:21];
   assign dec.ra   = instr[20:16];
   assign dec.rb   = instr[15:11];
   assign dec.disp = instr[DISP_W-1:0];

endmodule

// File: rtl/fsl_ea.sv
module fsl_ea
   import fsl_pkg::*;
#(
   parameter int GPR_W = 64,
   parameter int EA_W  = 32
)(
   input  ld_dec_t             dec,
   input  logic [GPR_W-1:0]    gpr_a,
   input  logic [GPR_W-1:0]    gpr_b,
   output logic                valid,
   output logic                illegal,
   output logic [RIDX_W-1:0]   fd,
   output logic [EA_W-1:0]     ea,
   output logic                wb_en,
   output logic [RIDX_W-1:0]   wb_idx,
   output logic [GPR_W-1:0]    wb_val
);

   localparam int SEXT_W = GPR_W - DISP_W;

   logic             is_upd;
   logic             is_idx;
   logic             is_load;
   logic             ra_zero;
   logic             bad_upd;
   logic [GPR_W-1:0] base;
   logic [GPR_W-1:0] offs;
   logic [GPR_W-1:0] sum;

   assign is_upd  = (dec.form == LDF_DISP_U) || (dec.form == LDF_IDX_U);
   assign is_idx  = (dec.form == LDF_IDX)    || (dec.form == LDF_IDX_U);
   assign is_load = (dec.form != LDF_NONE);
   assign ra_zero = (dec.ra == '0);
   assign bad_upd = is_upd && ra_zero;

   // non-update forms treat RA=0 as a literal zero base
   assign base = (ra_zero && !is_upd) ? '0 : gpr_a;
   assign offs = is_idx ? gpr_b : {{SEXT_W{dec.disp[DISP_W-1]}}, dec.disp};
   assign sum  = base + offs;

   assign ea      = sum[EA_W-1:0];
   assign valid   = is_load && !bad_upd;
   assign illegal = bad_upd;
   assign fd      = dec.fd;
   assign wb_en   = is_upd && !bad_upd;
   assign wb_idx  = dec.ra;
   assign wb_val  = GPR_W'(sum[EA_W-1:0]);

endmodule

// File: rtl/fsl_ostage.sv
module fsl_ostage #(
   parameter int W       = 8,
   parameter bit OUT_REG = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (OUT_REG) begin : g_reg
         logic [W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q_r <= '0;
            else
               q_r <= d;
         end
         assign q = q_r;
      end else begin : g_wire
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/fsl_agen.sv
module fsl_agen
   import fsl_pkg::*;
#(
   parameter int GPR_W   = 64,
   parameter int EA_W    = 32,
   parameter int PC_W    = 32,
   parameter bit OUT_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       i_instr,
   input  logic [PC_W-1:0]   i_pc,
   input  logic [GPR_W-1:0]  i_gpr_a,
   input  logic [GPR_W-1:0]  i_gpr_b,
   output logic              o_valid,
   output logic              o_illegal,
   output logic [4:0]        o_fd,
   output logic [EA_W-1:0]   o_ea,
   output logic              o_wb_en,
   output logic [4:0]        o_wb_idx,
   output logic [GPR_W-1:0]  o_wb_val,
   output logic [PC_W-1:0]   o_next_pc
);

   localparam int PKT_W = 1 + 1 + RIDX_W + EA_W + 1 + RIDX_W + GPR_W + PC_W;
   localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

   generate
      if (GPR_W < 32) begin : g_bad_gpr
         $error("fsl_agen: GPR_W must be at least 32");
      end
      if (EA_W > GPR_W || EA_W < 1) begin : g_bad_ea
         $error("fsl_agen: EA_W must lie in 1..GPR_W");
      end
      if (PC_W < 3) begin : g_bad_pc
         $error("fsl_agen: PC_W too small");
      end
   endgenerate

   ld_dec_t             dec;
   logic                c_valid;
   logic                c_illegal;
   logic [RIDX_W-1:0]   c_fd;
   logic [EA_W-1:0]     c_ea;
   logic                c_wb_en;
   logic [RIDX_W-1:0]   c_wb_idx;
   logic [GPR_W-1:0]    c_wb_val;
   logic [PC_W-1:0]     c_npc;
   logic [PKT_W-1:0]    pkt_d;
   logic [PKT_W-1:0]    pkt_q;

   fsl_dec u_dec (
      .instr (i_instr),
      .dec   (dec)
   );

   fsl_ea #(
      .GPR_W (GPR_W),
      .EA_W  (EA_W)
   ) u_ea (
      .dec     (dec),
      .gpr_a   (i_gpr_a),
      .gpr_b   (i_gpr_b),
      .valid   (c_valid),
      .illegal (c_illegal),
      .fd      (c_fd),
      .ea      (c_ea),
      .wb_en   (c_wb_en),
      .wb_idx  (c_wb_idx),
      .wb_val  (c_wb_val)
   );

   assign c_npc = i_pc + PC_STEP;

   assign pkt_d = {c_valid, c_illegal, c_fd, c_ea, c_wb_en, c_wb_idx, c_wb_val, c_npc};

   fsl_ostage #(
      .W       (PKT_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pkt_d),
      .q     (pkt_q)
   );

   assign {o_valid, o_illegal, o_fd, o_ea, o_wb_en, o_wb_idx, o_wb_val, o_next_pc} = pkt_q;

endmodule

// File: rtl/fsl_agen_chk.sv
module fsl_agen_chk #(
   parameter int GPR_W   = 64,
   parameter int EA_W    = 32,
   parameter int PC_W    = 32,
   parameter bit OUT_REG = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       i_instr,
   input logic [PC_W-1:0]   i_pc,
   input logic              o_valid,
   input logic              o_illegal,
   input logic [EA_W-1:0]   o_ea,
   input logic              o_wb_en,
   input logic [4:0]        o_wb_idx,
   input logic [GPR_W-1:0]  o_wb_val,
   input logic [PC_W-1:0]   o_next_pc
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R6/R7: a word is never both a legal load and an illegal form
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> !(o_valid && o_illegal));

   // R2/R4: writeback only for a legal load, never to register 0
   p_wb_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && o_wb_en) |-> (o_valid && (o_wb_idx != 5'd0)));

   // R6: the illegal form never requests a writeback
   p_ill_nowb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && o_illegal) |-> !o_wb_en);

   // R4: writeback value is the effective address
   p_wbval_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && o_wb_en) |-> (o_wb_val == GPR_W'(o_ea)));

   generate
      if (OUT_REG) begin : g_seq
         // R9/R10: next pc follows the pc one cycle earlier
         p_npc_r9: assert property (@(posedge clk) disable iff (!rst_n)
            armed |=> (o_next_pc == $past(i_pc) + PC_W'(4)));

         // R6: update-with-displacement and RA=0 raises illegal one cycle on
         p_ill_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && i_instr[31:26] == 6'd49 && i_instr[20:16] == 5'd0)
               |=> o_illegal);

         // R7: primary opcodes outside 31/48/49 yield nothing
         p_unknown_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && i_instr[31:26] != 6'd31 && i_instr[31:26] != 6'd48
               && i_instr[31:26] != 6'd49)
               |=> (!o_valid && !o_illegal && !o_wb_en));
      end
   endgenerate

endmodule

bind fsl_agen fsl_agen_chk #(
   .GPR_W   (GPR_W),
   .EA_W    (EA_W),
   .PC_W    (PC_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .i_instr   (i_instr),
   .i_pc      (i_pc),
   .o_valid   (o_valid),
   .o_illegal (o_illegal),
   .o_ea      (o_ea),
   .o_wb_en   (o_wb_en),
   .o_wb_idx  (o_wb_idx),
   .o_wb_val  (o_wb_val),
   .o_next_pc (o_next_pc)
);

// File: tb/sim_fsl_agen.sv
`timescale 1ns/1ps
module sim_fsl_agen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] i_instr = '0;
   logic [31:0] i_pc = '0;
   logic [63:0] i_gpr_a = '0;
   logic [63:0] i_gpr_b = '0;
   logic        o_valid;
   logic        o_illegal;
   logic [4:0]  o_fd;
   logic [31:0] o_ea;
   logic        o_wb_en;
   logic [4:0]  o_wb_idx;
   logic [63:0] o_wb_val;
   logic [31:0] o_next_pc;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   fsl_agen u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .i_instr   (i_instr),
      .i_pc      (i_pc),
      .i_gpr_a   (i_gpr_a),
      .i_gpr_b   (i_gpr_b),
      .o_valid   (o_valid),
      .o_illegal (o_illegal),
      .o_fd      (o_fd),
      .o_ea      (o_ea),
      .o_wb_en   (o_wb_en),
      .o_wb_idx  (o_wb_idx),
      .o_wb_val  (o_wb_val),
      .o_next_pc (o_next_pc)
   );

   function automatic logic [31:0] w_disp(input logic [5:0] op, input logic [4:0] fd,
                                          input logic [4:0] ra, input logic [15:0] d);
      return {op, fd, ra, d};
   endfunction

   function automatic logic [31:0] w_idx(input logic [9:0] xo, input logic [4:0] fd,
                                         input logic [4:0] ra, input logic [4:0] rb);
      return {6'd31, fd, ra, rb, xo, 1'b0};
   endfunction

   task automatic cmp(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic expect_all(input string req, input logic ev, input logic eill,
                             input logic [4:0] efd, input logic [31:0] eea,
                             input logic ewb, input logic [4:0] ewidx,
                             input logic [63:0] ewval, input logic [31:0] enpc);
      cmp(req, "valid",   {63'd0, o_valid},   {63'd0, ev});
      cmp(req, "illegal", {63'd0, o_illegal}, {63'd0, eill});
      if (ev) begin
         cmp(req, "fd", {59'd0, o_fd}, {59'd0, efd});
         cmp(req, "ea", {32'd0, o_ea}, {32'd0, eea});
      end
      cmp(req, "wb_en", {63'd0, o_wb_en}, {63'd0, ewb});
      if (ewb) begin
         cmp(req, "wb_idx", {59'd0, o_wb_idx}, {59'd0, ewidx});
         cmp(req, "wb_val", o_wb_val, ewval);
      end
      cmp(req, "next_pc", {32'd0, o_next_pc}, {32'd0, enpc});
   endtask

   // drive at a falling edge, let one rising edge capture, check at the next falling edge
   task automatic apply(input logic [31:0] ins, input logic [63:0] a,
                        input logic [63:0] b, input logic [31:0] pc);
      @(negedge clk);
      i_instr = ins; i_gpr_a = a; i_gpr_b = b; i_pc = pc;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      // R10: all outputs zero while reset is held
      i_instr = w_disp(6'd49, 5'd3, 5'd4, 16'h0010);
      i_gpr_a = 64'h100; i_pc = 32'h40;
      repeat (3) @(negedge clk);
      expect_all("R10", 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd0, 64'd0, 32'd0);
      cmp("R10", "fd_rst", {59'd0, o_fd}, 64'd0);
      cmp("R10", "ea_rst", {32'd0, o_ea}, 64'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_disp();
      // R1: displacement load, positive and negative displacement
      apply(w_disp(6'd48, 5'd7, 5'd9, 16'h0010), 64'h0000_0000_1000_0000, 64'h55, 32'h1000);
      expect_all("R1", 1, 0, 5'd7, 32'h1000_0010, 0, 5'd0, 64'd0, 32'h1004);
      apply(w_disp(6'd48, 5'd31, 5'd2, 16'hFFF0), 64'h0000_0000_0000_2000, 64'h0, 32'h2000);
      expect_all("R1", 1, 0, 5'd31, 32'h0000_1FF0, 0, 5'd0, 64'd0, 32'h2004);
   endtask

   task automatic t_disp_ra0();
      // R5: RA=0 means literal zero, value on gpr_a ignored
      apply(w_disp(6'd48, 5'd1, 5'd0, 16'h0123), 64'hDEAD_BEEF_DEAD_BEEF, 64'h0, 32'h3000);
      expect_all("R5", 1, 0, 5'd1, 32'h0000_0123, 0, 5'd0, 64'd0, 32'h3004);
      apply(w_disp(6'd48, 5'd1, 5'd0, 16'h8000), 64'h1234, 64'h0, 32'h3004);
      expect_all("R5", 1, 0, 5'd1, 32'hFFFF_8000, 0, 5'd0, 64'd0, 32'h3008);
   endtask

   task automatic t_disp_upd();
      // R2: update form writes the EA back to RA; upper bits truncated (R8)
      apply(w_disp(6'd49, 5'd5, 5'd12, 16'hFE00), 64'h1234_5678_0000_0100, 64'h0, 32'h4000);
      expect_all("R2", 1, 0, 5'd5, 32'hFFFF_FF00, 1, 5'd12, 64'h0000_0000_FFFF_FF00, 32'h4004);
   endtask

   task automatic t_idx();
      // R3: indexed load
      apply(w_idx(10'd535, 5'd8, 5'd3, 5'd4), 64'h0000_0000_0010_0000, 64'h0000_0000_0000_0ABC, 32'h5000);
      expect_all("R3", 1, 0, 5'd8, 32'h0010_0ABC, 0, 5'd0, 64'd0, 32'h5004);
      // R5: indexed with RA=0 uses only gpr_b
      apply(w_idx(10'd535, 5'd9, 5'd0, 5'd4), 64'hFFFF_0000_FFFF_0000, 64'h0000_0000_0000_0444, 32'h5004);
      expect_all("R5", 1, 0, 5'd9, 32'h0000_0444, 0, 5'd0, 64'd0, 32'h5008);
   endtask

   task automatic t_idx_upd();
      // R4: indexed with update
      apply(w_idx(10'd567, 5'd10, 5'd20, 5'd21), 64'h0000_0000_8000_0000, 64'h0000_0000_0000_1000, 32'h6000);
      expect_all("R4", 1, 0, 5'd10, 32'h8000_1000, 1, 5'd20, 64'h0000_0000_8000_1000, 32'h6004);
   endtask

   task automatic t_illegal();
      // R6: update forms with RA=0
      apply(w_disp(6'd49, 5'd2, 5'd0, 16'h0004), 64'h100, 64'h0, 32'h7000);
      expect_all("R6", 0, 1, 5'd0, 32'd0, 0, 5'd0, 64'd0, 32'h7004);
      apply(w_idx(10'd567, 5'd2, 5'd0, 5'd6), 64'h100, 64'h8, 32'h7004);
      expect_all("R6", 0, 1, 5'd0, 32'd0, 0, 5'd0, 64'd0, 32'h7008);
   endtask

   task automatic t_unknown();
      // R7: other opcodes and other extended opcodes
      apply(w_disp(6'd50, 5'd2, 5'd3, 16'h0004), 64'h100, 64'h0, 32'h8000);
      expect_all("R7", 0, 0, 5'd0, 32'd0, 0, 5'd0, 64'd0, 32'h8004);
      apply(w_idx(10'd23, 5'd2, 5'd0, 5'd6), 64'h100, 64'h8, 32'h8004);
      expect_all("R7", 0, 0, 5'd0, 32'd0, 0, 5'd0, 64'd0, 32'h8008);
      apply(w_idx(10'd599, 5'd2, 5'd3, 5'd6), 64'h100, 64'h8, 32'h8008);
      expect_all("R7", 0, 0, 5'd0, 32'd0, 0, 5'd0, 64'd0, 32'h800C);
   endtask

   task automatic t_wrap();
      // R8: 64-bit wrap then truncation
      apply(w_idx(10'd535, 5'd4, 5'd1, 5'd2), 64'hFFFF_FFFF_FFFF_FFFC, 64'h8, 32'h9000);
      expect_all("R8", 1, 0, 5'd4, 32'h0000_0004, 0, 5'd0, 64'd0, 32'h9004);
      apply(w_idx(10'd567, 5'd4, 5'd1, 5'd2), 64'h0000_0001_FFFF_FFF0, 64'h20, 32'h9004);
      expect_all("R8", 1, 0, 5'd4, 32'h0000_0010, 1, 5'd1, 64'h0000_0000_0000_0010, 32'h9008);
   endtask

   task automatic t_pc_wrap();
      // R9: pc wraps modulo 2^32
      apply(w_disp(6'd48, 5'd0, 5'd1, 16'h0000), 64'h40, 64'h0, 32'hFFFF_FFFC);
      expect_all("R9", 1, 0, 5'd0, 32'h0000_0040, 0, 5'd0, 64'd0, 32'h0000_0000);
   endtask

   task automatic t_latency();
      // R10: new inputs are not visible before the capturing edge
      apply(w_disp(6'd48, 5'd6, 5'd1, 16'h0008), 64'h100, 64'h0, 32'hA000);
      @(negedge clk);
      i_instr = w_disp(6'd49, 5'd11, 5'd2, 16'h0004);
      i_gpr_a = 64'h200; i_pc = 32'hA004;
      #3;
      cmp("R10", "ea_hold", {32'd0, o_ea}, 64'h108);
      cmp("R10", "wb_hold", {63'd0, o_wb_en}, 64'd0);
      @(posedge clk);
      @(negedge clk);
      expect_all("R10", 1, 0, 5'd11, 32'h0000_0204, 1, 5'd2, 64'h204, 32'hA008);
   endtask

   initial begin
      t_reset();
      t_disp();
      t_disp_ra0();
      t_disp_upd();
      t_idx();
      t_idx_upd();
      t_illegal();
      t_unknown();
      t_wrap();
      t_pc_wrap();
      t_latency();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule